// File: doc/BRIEF.md
# Queued Scatter-Gather Memory Copy Engine

This block copies words from one part of memory to another with no processor help once a job is queued. Software places a pointer to a descriptor chain into a four-entry job queue. The engine takes jobs from the queue one after another. For each job it walks the chain of descriptors held in memory. Each descriptor names a source run, a destination run and a word count. Linking several descriptors gathers scattered source runs into one contiguous region, or scatters one region across several places.

All memory traffic, descriptor reads included, goes over a shared bus through a request/grant pair. An access takes place in any cycle where the request and the grant are both high. Read data returns in that same cycle. A two-bit mode input sets how the engine treats the bus:
- **Full-hold:** it keeps the bus for the whole job.
- **Steal:** it takes a single cycle and then gives the bus back for at least one cycle.
- **Idle-only:** it asks only in cycles where the processor is not asking.

Each finished job gives three results:
- a one-cycle completion pulse;
- a count of the words the job moved;
- a sticky interrupt flag that software clears with a one-cycle clear pulse.

A push into a full queue is dropped and sets a sticky overflow flag.

Top module: `sgdma_engine`

## Requirements
- R1: Queued jobs run one after another in push order, with no host action between them. A job whose push was rejected never runs.
- R2: Data words move from each descriptor's source run to its destination run at rising addresses. The destination of each word holds the source value when the job completes.
- R3: A descriptor is three consecutive memory words at pointer P:
  - P holds the source address.
  - P+1 holds the destination address.
  - P+2 holds the word count in bits [15:0] and the last-descriptor flag in bit 31.

  The next descriptor starts at P+3. The walk stops after the descriptor whose last flag is 1.
- R4: With mode 2'b00 (full-hold; 2'b11 behaves the same), the bus request rises once per job and stays high until the job's final access.
- R5: With mode 2'b01 (steal), the engine never makes accesses in two consecutive cycles.
- R6: With mode 2'b10 (idle-only), the bus request is never high in a cycle where `cpu_req_i` is high.
- R7: The job queue holds 4 pointers. A push while 4 are held is dropped and sets `ovf_o`. `ovf_o` stays set until an `ovf_clr_i` pulse.
- R8: Each finished job sets `irq_o`. `irq_o` stays set until an `irq_clr_i` pulse.
- R9: A descriptor with a word count of 0 causes no data access: only its three descriptor words are read.
- R10: Each finished job gives one `cmd_done_o` pulse. While that pulse is high, `cmd_words_o` holds the number of words the job moved.
- R11: After reset, `irq_o`, `ovf_o`, `cmd_done_o` and `bus_req_o` are all 0.
- R12: The mode is sampled when a job starts and holds for the whole job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bus policy: 00 full-hold, 01 steal, 10 idle-only, 11 full-hold |
| cmd_push_i | input | 1 | Push one job pointer into the queue |
| cmd_desc_i | input | AW | Address of the first descriptor of the pushed job |
| irq_clr_i | input | 1 | Clear pulse for the interrupt flag |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |
| irq_o | output | 1 | Sticky job-complete interrupt |
| ovf_o | output | 1 | Sticky queue-overflow flag |
| cmd_done_o | output | 1 | One-cycle pulse at job completion |
| cmd_words_o | output | CW | Words moved by the finishing job |
| cpu_req_i | input | 1 | The processor is requesting the bus this cycle |
| bus_req_o | output | 1 | The engine requests the bus |
| bus_gnt_i | input | 1 | Bus grant to the engine |
| bus_addr_o | output | AW | Access address |
| bus_we_o | output | 1 | 1 for a write, 0 for a read |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid in the access cycle |

## Verification
The bench checks each bus policy by counting accesses, rises of the request and back-to-back accesses during a job:
- A full-hold engine that let the request drop between descriptors would show more than one rise.
- A steal engine that failed to back off would show consecutive accesses.
- An idle-only engine that ignored the processor would show an access during a processor cycle.

A zero-count descriptor sits in the middle of a chain, and a chain holding only a zero-count last descriptor is also run. An engine that still read and wrote one word would disturb a sentinel word and show extra accesses. A last-flagged empty chain that was mishandled would hang or report a nonzero word count.

With the bus stalled, a fifth queued push (the sixth job pushed) checks overflow. A queue that accepted it, or wrapped over an entry, would run the wrong number of jobs once the bus is released.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'b00,
        MODE_STEAL  = 2'b01,
        MODE_IDLE   = 2'b10,
        MODE_HOLD2  = 2'b11
    } bus_mode_e;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_FSRC,
        WK_FDST,
        WK_FLEN,
        WK_READ,
        WK_WRITE,
        WK_DONE
    } walk_state_e;

    localparam int DESC_WORDS = 3;

endpackage

// File: rtl/sgdma_cmdq.sv
module sgdma_cmdq #(
    parameter int DEPTH = 4,
    parameter int AW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_data_i,
    input  logic          pop_i,
    input  logic          ovf_clr_i,
    output logic [AW-1:0] head_o,
    output logic          empty_o,
    output logic          ovf_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] slot;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [PW:0]              cnt;
        logic                     ovf;
    } q_state_t;

    q_state_t s_q, s_d;
    logic full, do_pop;

    always_comb begin
        s_d    = s_q;
        full   = (s_q.cnt == (PW+1)'(DEPTH));
        do_pop = pop_i && (s_q.cnt != '0);
        if (do_pop) begin
            s_d.rp = (s_q.rp == PW'(DEPTH-1)) ? '0 : s_q.rp + PW'(1);
        end
        if (push_i && !full) begin
            s_d.slot[s_q.wp] = push_data_i;
            s_d.wp = (s_q.wp == PW'(DEPTH-1)) ? '0 : s_q.wp + PW'(1);
        end
        s_d.cnt = s_q.cnt + (PW+1)'(push_i && !full) - (PW+1)'(do_pop);
        if (ovf_clr_i) s_d.ovf = 1'b0;
        if (push_i && full) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_o  = s_q.slot[s_q.rp];
    assign empty_o = (s_q.cnt == '0);
    assign ovf_o   = s_q.ovf;

    AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && s_q.cnt == (PW+1)'(DEPTH)) |=> ovf_o); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= (PW+1)'(DEPTH)); // R7
endmodule

// File: rtl/sgdma_bus_policy.sv
module sgdma_bus_policy
    import sgdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_e mode_i,
    input  logic      need_i,
    input  logic      cpu_req_i,
    input  logic      gnt_i,
    output logic      req_o,
    output logic      acc_o
);
    typedef struct packed {
        logic acc;
    } pol_state_t;

    pol_state_t s_q, s_d;

    always_comb begin
        unique case (mode_i)
            MODE_STEAL: req_o = need_i && !s_q.acc;
            MODE_IDLE:  req_o = need_i && !cpu_req_i;
            default:    req_o = need_i;
        endcase
        acc_o     = req_o && gnt_i;
        s_d.acc   = acc_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_STEAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_STEAL && acc_o) |=> !acc_o); // R5
    AST_BG_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_IDLE && req_o) |-> !cpu_req_i); // R6
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
    import sgdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_empty_i,
    input  logic [AW-1:0] q_head_i,
    output logic          q_pop_o,
    input  logic [1:0]    mode_i,
    output bus_mode_e     mode_o,
    output logic          need_o,
    input  logic          acc_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [DW-1:0] wdata_o,
    input  logic [DW-1:0] rdata_i,
    output logic          done_o,
    output logic [CW-1:0] words_o
);
    typedef struct packed {
        walk_state_e   st;
        bus_mode_e     mode;
        logic [AW-1:0] ptr;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic          last;
        logic [DW-1:0] data;
        logic [CW-1:0] words;
    } wk_state_t;

    wk_state_t s_q, s_d;
    walk_state_e after_run;
    logic [LW-1:0] rd_len;

    always_comb begin
        s_d       = s_q;
        q_pop_o   = 1'b0;
        need_o    = 1'b0;
        addr_o    = '0;
        we_o      = 1'b0;
        wdata_o   = '0;
        done_o    = 1'b0;
        rd_len    = rdata_i[LW-1:0];
        after_run = s_q.last ? WK_DONE : WK_FSRC;
        unique case (s_q.st)
            WK_IDLE: begin
                if (!q_empty_i) begin
                    q_pop_o  = 1'b1;
                    s_d.ptr  = q_head_i;
                    s_d.words = '0;
                    s_d.mode = bus_mode_e'(mode_i);
                    s_d.st   = WK_FSRC;
                end
            end
            WK_FSRC: begin
                need_o = 1'b1;
                addr_o = s_q.ptr;
                if (acc_i) begin
                    s_d.src = rdata_i[AW-1:0];
                    s_d.st  = WK_FDST;
                end
            end
            WK_FDST: begin
                need_o = 1'b1;
                addr_o = s_q.ptr + AW'(1);
                if (acc_i) begin
                    s_d.dst = rdata_i[AW-1:0];
                    s_d.st  = WK_FLEN;
                end
            end
            WK_FLEN: begin
                need_o = 1'b1;
                addr_o = s_q.ptr + AW'(2);
                if (acc_i) begin
                    s_d.len  = rd_len;
                    s_d.last = rdata_i[DW-1];
                    s_d.ptr  = s_q.ptr + AW'(DESC_WORDS);
                    if (rd_len == '0) s_d.st = rdata_i[DW-1] ? WK_DONE : WK_FSRC;
                    else              s_d.st = WK_READ;
                end
            end
            WK_READ: begin
                need_o = 1'b1;
                addr_o = s_q.src;
                if (acc_i) begin
                    s_d.data = rdata_i;
                    s_d.st   = WK_WRITE;
                end
            end
            WK_WRITE: begin
                need_o  = 1'b1;
                addr_o  = s_q.dst;
                we_o    = 1'b1;
                wdata_o = s_q.data;
                if (acc_i) begin
                    s_d.src   = s_q.src + AW'(1);
                    s_d.dst   = s_q.dst + AW'(1);
                    s_d.len   = s_q.len - LW'(1);
                    s_d.words = s_q.words + CW'(1);
                    s_d.st    = (s_q.len == LW'(1)) ? after_run : WK_READ;
                end
            end
            WK_DONE: begin
                done_o = 1'b1;
                s_d.st = WK_IDLE;
            end
            default: s_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= WK_IDLE;
            s_q.mode <= MODE_HOLD;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o  = s_q.mode;
    assign words_o = s_q.words;

    AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == WK_FLEN && acc_i && rd_len == '0) |=> (s_q.st != WK_READ)); // R9
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != WK_IDLE && $past(s_q.st) != WK_IDLE) |-> $stable(s_q.mode)); // R12
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LW    = 16,
    parameter int CW    = 16,
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          cmd_push_i,
    input  logic [AW-1:0] cmd_desc_i,
    input  logic          irq_clr_i,
    input  logic          ovf_clr_i,
    output logic          irq_o,
    output logic          ovf_o,
    output logic          cmd_done_o,
    output logic [CW-1:0] cmd_words_o,
    input  logic          cpu_req_i,
    output logic          bus_req_o,
    input  logic          bus_gnt_i,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_we_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic [DW-1:0] bus_rdata_i
);
    logic [AW-1:0] q_head;
    logic          q_empty, q_pop, need, acc;
    bus_mode_e     run_mode;

    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t s_q, s_d;

    sgdma_cmdq #(.DEPTH(QDEPTH), .AW(AW)) u_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(cmd_push_i), .push_data_i(cmd_desc_i),
        .pop_i(q_pop), .ovf_clr_i(ovf_clr_i),
        .head_o(q_head), .empty_o(q_empty), .ovf_o(ovf_o)
    );

    sgdma_walker #(.AW(AW), .DW(DW), .LW(LW), .CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .q_empty_i(q_empty), .q_head_i(q_head), .q_pop_o(q_pop),
        .mode_i(mode_i), .mode_o(run_mode),
        .need_o(need), .acc_i(acc),
        .addr_o(bus_addr_o), .we_o(bus_we_o), .wdata_o(bus_wdata_o),
        .rdata_i(bus_rdata_i),
        .done_o(cmd_done_o), .words_o(cmd_words_o)
    );

    sgdma_bus_policy u_pol (
        .clk(clk), .rst_n(rst_n),
        .mode_i(run_mode), .need_i(need), .cpu_req_i(cpu_req_i),
        .gnt_i(bus_gnt_i), .req_o(bus_req_o), .acc_o(acc)
    );

    always_comb begin
        s_d = s_q;
        if (irq_clr_i)  s_d.irq = 1'b0;
        if (cmd_done_o) s_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o = s_q.irq;

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_o |=> irq_o); // R8
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_mode == MODE_HOLD || run_mode == MODE_HOLD2) && bus_req_o && !bus_gnt_i)
        |=> bus_req_o); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_o |-> !bus_req_o); // R10
endmodule

// File: tb/tb_sgdma_engine.sv
module tb_sgdma_engine;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          push = 1'b0;
    logic [AW-1:0] push_ptr = '0;
    logic          irq_clr = 1'b0, ovf_clr = 1'b0;
    logic          irq, ovf, done;
    logic [CW-1:0] words;
    logic          cpu_req = 1'b0;
    logic          breq, bgnt, bwe;
    logic [AW-1:0] baddr;
    logic [DW-1:0] bwdata, brdata;
    logic          gnt_en = 1'b1;
    logic          cpu_pat = 1'b0;

    logic [DW-1:0] mem [0:255];

    int checks = 0, fails = 0;
    int n_acc = 0, n_rise = 0, n_consec = 0, n_clash = 0, n_done = 0, cyc = 0;
    logic prev_req = 1'b0, prev_acc = 1'b0;

    always #2 clk = ~clk;

    assign bgnt   = gnt_en & breq;
    assign brdata = mem[baddr[7:0]];

    sgdma_engine dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .cmd_push_i(push), .cmd_desc_i(push_ptr),
        .irq_clr_i(irq_clr), .ovf_clr_i(ovf_clr),
        .irq_o(irq), .ovf_o(ovf), .cmd_done_o(done), .cmd_words_o(words),
        .cpu_req_i(cpu_req), .bus_req_o(breq), .bus_gnt_i(bgnt),
        .bus_addr_o(baddr), .bus_we_o(bwe), .bus_wdata_o(bwdata),
        .bus_rdata_i(brdata)
    );

    always @(posedge clk) begin
        if (breq && bgnt && bwe) mem[baddr[7:0]] <= bwdata;
        if (rst_n) begin
            if (breq && bgnt) n_acc <= n_acc + 1;
            if (breq && !prev_req) n_rise <= n_rise + 1;
            if (breq && bgnt && prev_acc) n_consec <= n_consec + 1;
            if (breq && cpu_req) n_clash <= n_clash + 1;
            if (done) n_done <= n_done + 1;
            prev_req <= breq;
            prev_acc <= breq && bgnt;
        end
        cyc <= cyc + 1;
    end

    always @(negedge clk) cpu_req <= cpu_pat && ((cyc % 3) != 2);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int at, input int src, input int dst, input int len, input bit last);
        mem[at]   = DW'(src);
        mem[at+1] = DW'(dst);
        mem[at+2] = {last, 15'd0, 16'(len)};
    endtask

    task automatic push_job(input int ptr);
        @(negedge clk);
        push = 1'b1; push_ptr = AW'(ptr);
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic wait_done(input string req, output int w);
        bit seen = 0;
        w = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; w = int'(words); end
        end
        chk(req, "job completion seen", seen, 1);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11", "irq after reset", irq, 0);
        chk("R11", "ovf after reset", ovf, 0);
        chk("R11", "done after reset", done, 0);
        chk("R11", "req after reset", breq, 0);
    endtask

    task automatic t_hold_gather;
        int a0, r0, w;
        for (int i = 0; i < 5; i++) begin
            mem[8'h40 + i] = 32'h1000 + i;
            mem[8'h50 + i] = 32'h2000 + i;
        end
        put_desc(8'h10, 8'h40, 8'h80, 2, 0);
        put_desc(8'h13, 8'h50, 8'h82, 3, 1);
        mode = 2'b00;
        a0 = n_acc; r0 = n_rise;
        push_job(8'h10);
        wait_done("R10", w);
        chk("R10", "words moved", w, 5);
        chk("R2", "gather word0", mem[8'h80], 32'h1000);
        chk("R2", "gather word1", mem[8'h81], 32'h1001);
        chk("R3", "second descriptor word0", mem[8'h82], 32'h2000);
        chk("R3", "second descriptor word2", mem[8'h84], 32'h2002);
        chk("R4", "accesses in hold job", n_acc - a0, 16);
        chk("R4", "request rises in hold job", n_rise - r0, 1);
        chk("R8", "irq after job", irq, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk("R8", "irq after clear pulse", irq, 0);
    endtask

    task automatic t_steal_scatter;
        int a0, r0, c0, w;
        for (int i = 0; i < 4; i++) mem[8'h60 + i] = 32'h3000 + i;
        put_desc(8'h18, 8'h60, 8'h90, 2, 0);
        put_desc(8'h1B, 8'h62, 8'hA0, 2, 1);
        mode = 2'b01;
        a0 = n_acc; r0 = n_rise; c0 = n_consec;
        push_job(8'h18);
        wait_done("R5", w);
        chk("R2", "scatter first run", mem[8'h91], 32'h3001);
        chk("R2", "scatter second run", mem[8'hA0], 32'h3002);
        chk("R2", "scatter second run end", mem[8'hA1], 32'h3003);
        chk("R5", "back-to-back accesses in steal job", n_consec - c0, 0);
        chk("R5", "accesses in steal job", n_acc - a0, 14);
        chk("R5", "request rises in steal job", n_rise - r0, 14);
        chk("R10", "steal job words", w, 4);
    endtask

    task automatic t_idle_only;
        int k0, w;
        for (int i = 0; i < 3; i++) mem[8'h70 + i] = 32'h4000 + i;
        put_desc(8'h1E, 8'h70, 8'hB0, 3, 1);
        mode = 2'b10;
        cpu_pat = 1'b1;
        k0 = n_clash;
        push_job(8'h1E);
        wait_done("R6", w);
        cpu_pat = 1'b0;
        chk("R6", "requests during cpu cycles", n_clash - k0, 0);
        chk("R6", "idle-only data end", mem[8'hB2], 32'h4002);
        chk("R10", "idle-only words", w, 3);
    endtask

    task automatic t_zero_len;
        int a0, w;
        mem[8'hC0] = 32'hDEAD;
        mem[8'h44] = 32'h5000; mem[8'h45] = 32'h5001;
        put_desc(8'h20, 8'h46, 8'hC0, 0, 0);
        put_desc(8'h23, 8'h44, 8'hC4, 2, 1);
        mode = 2'b00;
        a0 = n_acc;
        push_job(8'h20);
        wait_done("R9", w);
        chk("R9", "accesses with empty descriptor", n_acc - a0, 10);
        chk("R9", "sentinel untouched", mem[8'hC0], 32'hDEAD);
        chk("R9", "following descriptor moved", mem[8'hC5], 32'h5001);
        put_desc(8'h26, 8'h44, 8'hC0, 0, 1);
        a0 = n_acc;
        push_job(8'h26);
        wait_done("R9", w);
        chk("R9", "lone empty last descriptor accesses", n_acc - a0, 3);
        chk("R10", "lone empty job words", w, 0);
    endtask

    task automatic t_queue_full;
        int d0;
        mem[8'h48] = 32'h6000;
        put_desc(8'h30, 8'h48, 8'hD0, 1, 1);
        mode = 2'b00;
        gnt_en = 1'b0;
        d0 = n_done;
        push_job(8'h30);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) push_job(8'h30);
        chk("R7", "ovf with queue just full", ovf, 0);
        push_job(8'h30);
        chk("R7", "ovf after rejected push", ovf, 1);
        gnt_en = 1'b1;
        repeat (200) @(negedge clk);
        chk("R1", "jobs run from queue", n_done - d0, 5);
        chk("R7", "ovf sticky", ovf, 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R7", "ovf after clear pulse", ovf, 0);
    endtask

    task automatic t_mode_latch;
        int c0, w;
        for (int i = 0; i < 3; i++) mem[8'h4C + i] = 32'h7000 + i;
        put_desc(8'h34, 8'h4C, 8'hE0, 3, 1);
        mode = 2'b01;
        c0 = n_consec;
        push_job(8'h34);
        repeat (2) @(negedge clk);
        mode = 2'b00;
        wait_done("R12", w);
        chk("R12", "steal kept after mode change", n_consec - c0, 0);
        chk("R12", "data with mode change", mem[8'hE2], 32'h7002);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_hold_gather;
        t_steal_scatter;
        t_idle_only;
        t_zero_len;
        t_queue_full;
        t_mode_latch;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule